// File: doc/BRIEF.md
# Priority Masked Action Resolver

This block turns a receive classification tag into one action for a packet. It holds a table of records, each with a requested tag, a per-bit care mask and an action code. Every lookup compares the 32-bit input tag against all live records in parallel. A record is live when its section is enabled and its action is not the neutral code. The action of the lowest-numbered matching record wins. The input tag carries the 3-bit VLAN priority in bits [31:29] and 29 upstream filter tag bits in [28:0]. The comparison treats all 32 bits alike, so a record that cares only about the priority simply masks bits [31:29].

Records and the section-enable vector change only through one write port. That port is guarded by an ownership semaphore. A master polls its acquire line until its grant bit reads 1. It then writes and gives ownership back with a release strobe. Bounding the polling is up to the master.

Top module: `act_match_table`

## Requirements
- R1: After reset the semaphore is free (`gnt_o` = 0), all sections are enabled and every record holds the neutral action, so no lookup hits.
- R2: `res_valid_o` is high in the cycle after a cycle with `lk_valid_i` high, and low otherwise; the result fields are registered at that same edge.
- R3: A record matches when `(lk_tag_i ^ tag) & mask` is zero; a mask of 0 matches every tag, and a mask of all ones requires an exact match.
- R4: When several live records match, `res_idx_o` is the lowest matching index and `res_act_o` is that record's action.
- R5: Record i belongs to section i/4 (`NUM_REC/SEC_N` records per section); a record whose bit in the section-enable vector is 0 never matches.
- R6: A record whose action opcode (bits [15:12]) is 2 (neutral) never matches. The other opcodes are 0 pass, 1 drop, 3 assign traffic class, and 4 assign queue. Bits [11:0] carry the argument.
- R7: When no live record matches, `res_hit_o` is 0, `res_idx_o` is 0 and `res_act_o` is 16'h0000 (pass, no override).
- R8: An acquire strobe while the semaphore is free grants it to the lowest-numbered requesting master on the next cycle. An acquire while it is held leaves the owner unchanged.
- R9: Only the owner's release strobe frees the semaphore; a release from another master is ignored.
- R10: A record or section write is applied only when `wr_id_i` names the current owner; any other write leaves the table unchanged.
- R11: A write affects lookups presented from the next cycle onward. A lookup presented in the same cycle as the write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acq_i | input | NUM_MST | Per-master acquire strobe |
| rel_i | input | NUM_MST | Per-master release strobe |
| gnt_o | output | NUM_MST | One-hot current owner, 0 when free |
| wr_en_i | input | 1 | Record write strobe |
| wr_id_i | input | MST_W | Master issuing the write |
| wr_addr_i | input | IDX_W | Record index to write |
| wr_tag_i | input | TAG_W | Requested tag |
| wr_mask_i | input | TAG_W | Care mask, 1 = compare |
| wr_act_i | input | 16 | Action code |
| sec_wr_i | input | 1 | Section-enable write strobe |
| sec_val_i | input | SEC_N | New section-enable vector |
| lk_valid_i | input | 1 | Lookup strobe |
| lk_tag_i | input | TAG_W | Lookup tag |
| res_valid_o | output | 1 | Result valid |
| res_hit_o | output | 1 | Some live record matched |
| res_idx_o | output | IDX_W | Winning record index |
| res_act_o | output | 16 | Winning action, or pass |

## Verification
The bench uses the default parameters: 64 records, 16 sections of four and two masters. This puts the priority records in the middle of the table, where a low-index catch-all can overtake them. Switching off a pair of sections then hands the win to a record further up. Two masters are enough to exercise simultaneous acquisition, foreign releases and foreign writes. The write-then-lookup ordering is tested with a write and a lookup presented in the same cycle.

// File: rtl/act_table_pkg.sv
package act_table_pkg;
  localparam int ACT_W = 16;

  typedef enum logic [3:0] {
    OP_PASS    = 4'd0,
    OP_DROP    = 4'd1,
    OP_NEUTRAL = 4'd2,
    OP_TC      = 4'd3,
    OP_QUEUE   = 4'd4
  } act_op_e;

  typedef struct packed {
    act_op_e     op;
    logic [11:0] arg;
  } act_t;
endpackage

// File: rtl/act_sem.sv
module act_sem #(
  parameter int NUM_MST = 2,
  parameter int MST_W   = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_MST-1:0] acq_i,
  input  logic [NUM_MST-1:0] rel_i,
  output logic [NUM_MST-1:0] gnt_o,
  output logic               held_o,
  output logic [MST_W-1:0]   owner_o
);
  logic             held_q;
  logic [MST_W-1:0] owner_q;
  logic [MST_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int m = NUM_MST - 1; m >= 0; m--)
      if (acq_i[m]) pick = MST_W'(m);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= 1'b0;
      owner_q <= '0;
    end else if (held_q) begin
      if (rel_i[owner_q]) held_q <= 1'b0;
    end else if (|acq_i) begin
      held_q  <= 1'b1;
      owner_q <= pick;
    end
  end

  always_comb begin
    gnt_o = '0;
    if (held_q) gnt_o[owner_q] = 1'b1;
  end

  assign held_o  = held_q;
  assign owner_o = owner_q;

  // R8
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R9
  owner_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && (rel_i & gnt_o) == '0) |=> $stable(gnt_o));

  // R8
  free_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0 && acq_i != '0) |=> gnt_o != '0);
endmodule

// File: rtl/act_rec_store.sv
module act_rec_store
  import act_table_pkg::*;
#(
  parameter int NUM_REC = 64,
  parameter int TAG_W   = 32,
  parameter int SEC_N   = 16,
  parameter int IDX_W   = $clog2(NUM_REC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_addr_i,
  input  logic [TAG_W-1:0]   wr_tag_i,
  input  logic [TAG_W-1:0]   wr_mask_i,
  input  act_t               wr_act_i,
  input  logic               sec_wr_i,
  input  logic [SEC_N-1:0]   sec_val_i,
  input  logic [TAG_W-1:0]   tag_i,
  output logic [NUM_REC-1:0] hit_o,
  output act_t               act_o [NUM_REC]
);
  localparam int PER_SEC = NUM_REC / SEC_N;

  logic [SEC_N-1:0] sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sec_q <= '1;
    else if (sec_wr_i) sec_q <= sec_val_i;
  end

  for (genvar i = 0; i < NUM_REC; i++) begin : g_rec
    logic [TAG_W-1:0] tag_q, mask_q;
    act_t             act_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q  <= '0;
        mask_q <= '0;
        act_q  <= '{op: OP_NEUTRAL, arg: '0};
      end else if (wr_en_i && wr_addr_i == IDX_W'(i)) begin
        tag_q  <= wr_tag_i;
        mask_q <= wr_mask_i;
        act_q  <= wr_act_i;
      end
    end

    assign hit_o[i] = sec_q[i / PER_SEC] && (act_q.op != OP_NEUTRAL) &&
                      (((tag_i ^ tag_q) & mask_q) == '0);
    assign act_o[i] = act_q;
  end
endmodule

// File: rtl/act_prio_pick.sv
module act_prio_pick #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     hit_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (hit_i[i]) idx_o = IDX_W'(i);
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/act_match_table.sv
module act_match_table
  import act_table_pkg::*;
#(
  parameter int NUM_REC = 64,
  parameter int TAG_W   = 32,
  parameter int SEC_N   = 16,
  parameter int NUM_MST = 2,
  parameter int IDX_W   = $clog2(NUM_REC),
  parameter int MST_W   = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_MST-1:0] acq_i,
  input  logic [NUM_MST-1:0] rel_i,
  output logic [NUM_MST-1:0] gnt_o,
  input  logic               wr_en_i,
  input  logic [MST_W-1:0]   wr_id_i,
  input  logic [IDX_W-1:0]   wr_addr_i,
  input  logic [TAG_W-1:0]   wr_tag_i,
  input  logic [TAG_W-1:0]   wr_mask_i,
  input  logic [ACT_W-1:0]   wr_act_i,
  input  logic               sec_wr_i,
  input  logic [SEC_N-1:0]   sec_val_i,
  input  logic               lk_valid_i,
  input  logic [TAG_W-1:0]   lk_tag_i,
  output logic               res_valid_o,
  output logic               res_hit_o,
  output logic [IDX_W-1:0]   res_idx_o,
  output logic [ACT_W-1:0]   res_act_o
);
  logic               held;
  logic [MST_W-1:0]   owner;
  logic               own_ok;
  logic [NUM_REC-1:0] hit_vec;
  act_t               act_arr [NUM_REC];
  logic               any_hit;
  logic [IDX_W-1:0]   win_idx;

  act_sem #(.NUM_MST(NUM_MST), .MST_W(MST_W)) i_sem (
    .clk_i, .rst_ni, .acq_i, .rel_i, .gnt_o,
    .held_o(held), .owner_o(owner)
  );

  assign own_ok = held && (owner == wr_id_i);

  act_rec_store #(.NUM_REC(NUM_REC), .TAG_W(TAG_W), .SEC_N(SEC_N), .IDX_W(IDX_W)) i_store (
    .clk_i, .rst_ni,
    .wr_en_i  (wr_en_i && own_ok),
    .wr_addr_i,
    .wr_tag_i,
    .wr_mask_i,
    .wr_act_i (act_t'(wr_act_i)),
    .sec_wr_i (sec_wr_i && own_ok),
    .sec_val_i,
    .tag_i    (lk_tag_i),
    .hit_o    (hit_vec),
    .act_o    (act_arr)
  );

  act_prio_pick #(.N(NUM_REC), .IDX_W(IDX_W)) i_pick (
    .hit_i(hit_vec), .any_o(any_hit), .idx_o(win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_hit_o   <= 1'b0;
      res_idx_o   <= '0;
      res_act_o   <= '0;
    end else begin
      res_valid_o <= lk_valid_i;
      if (lk_valid_i) begin
        res_hit_o <= any_hit;
        res_idx_o <= win_idx;
        res_act_o <= any_hit ? ACT_W'(act_arr[win_idx]) : '0;
      end
    end
  end

  // R2
  res_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> res_valid_o);

  // R2
  res_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !res_valid_o);

  // R7
  miss_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_hit_o) |-> (res_act_o == '0 && res_idx_o == '0));

  // R6
  hit_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_hit_o) |-> res_act_o[15:12] != 4'd2);
endmodule

// File: tb/test_act_match_table.sv
module test_act_match_table;
  localparam int IW = 6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  acq = '0, rel = '0, gnt;
  logic        wr_en = 1'b0, sec_wr = 1'b0, lk_valid = 1'b0;
  logic [0:0]  wr_id = '0;
  logic [IW-1:0] wr_addr = '0, res_idx;
  logic [31:0] wr_tag = '0, wr_mask = '0, lk_tag = '0;
  logic [15:0] wr_act = '0, res_act, sec_val = '1;
  logic        res_valid, res_hit;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  act_match_table i_act_match_table (
    .clk_i(clk), .rst_ni(rst_n), .acq_i(acq), .rel_i(rel), .gnt_o(gnt),
    .wr_en_i(wr_en), .wr_id_i(wr_id), .wr_addr_i(wr_addr), .wr_tag_i(wr_tag),
    .wr_mask_i(wr_mask), .wr_act_i(wr_act), .sec_wr_i(sec_wr), .sec_val_i(sec_val),
    .lk_valid_i(lk_valid), .lk_tag_i(lk_tag), .res_valid_o(res_valid),
    .res_hit_o(res_hit), .res_idx_o(res_idx), .res_act_o(res_act)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] t);
    @(negedge clk); lk_valid = 1'b1; lk_tag = t;
    @(negedge clk); lk_valid = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic h, input int idx, input logic [15:0] a);
    check({req, " valid"}, 32'(res_valid), 32'd1);
    check({req, " hit"}, 32'(res_hit), 32'(h));
    check({req, " idx"}, 32'(res_idx), 32'(idx));
    check({req, " act"}, 32'(res_act), 32'(a));
  endtask

  task automatic wr_rec(input logic id, input int a, input logic [31:0] t,
                        input logic [31:0] m, input logic [15:0] act);
    @(negedge clk); wr_en = 1'b1; wr_id = id; wr_addr = IW'(a);
    wr_tag = t; wr_mask = m; wr_act = act;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_sec(input logic id, input logic [15:0] v);
    @(negedge clk); sec_wr = 1'b1; wr_id = id; sec_val = v;
    @(negedge clk); sec_wr = 1'b0;
  endtask

  task automatic sem(input logic [1:0] a, input logic [1:0] r);
    @(negedge clk); acq = a; rel = r;
    @(negedge clk); acq = '0; rel = '0;
  endtask

  task automatic t_reset;
    check("R1 gnt", 32'(gnt), 32'd0);
    lookup(32'h0000_0000);
    expect_res("R1 R7 empty", 1'b0, 0, 16'h0000);
    @(negedge clk);
    check("R2 valid drop", 32'(res_valid), 32'd0);
  endtask

  task automatic t_sem_acquire;
    sem(2'b11, 2'b00);
    check("R8 lowest wins", 32'(gnt), 32'd1);
    sem(2'b10, 2'b00);
    check("R8 held", 32'(gnt), 32'd1);
    sem(2'b00, 2'b10);
    check("R9 foreign release", 32'(gnt), 32'd1);
  endtask

  task automatic t_exact;
    wr_rec(1'b0, 30, 32'h1234_5678, 32'hFFFF_FFFF, 16'h4005);
    lookup(32'h1234_5678);
    expect_res("R3 exact", 1'b1, 30, 16'h4005);
    lookup(32'h1234_5679);
    expect_res("R3 exact miss", 1'b0, 0, 16'h0000);
  endtask

  task automatic t_foreign_write;
    wr_rec(1'b1, 0, 32'h0, 32'h0, 16'h1000);
    lookup(32'h1234_5679);
    expect_res("R10 record", 1'b0, 0, 16'h0000);
    wr_sec(1'b1, 16'h0000);
    lookup(32'h1234_5678);
    expect_res("R10 section", 1'b1, 30, 16'h4005);
  endtask

  task automatic t_pcp;
    for (int p = 0; p < 8; p++)
      wr_rec(1'b0, 8 + p, 32'(p) << 29, 32'hE000_0000, 16'h3000 | 16'(7 - p));
    lookup({3'd3, 29'h0ABC_DEF});
    expect_res("R3 pcp3", 1'b1, 11, 16'h3004);
    lookup({3'd0, 29'h1FFF_FFFF});
    expect_res("R3 pcp0", 1'b1, 8, 16'h3007);
    wr_rec(1'b0, 20, 32'h0, 32'h0, 16'h1000);
    lookup({3'd5, 29'h0});
    expect_res("R4 lower beats catch-all", 1'b1, 13, 16'h3002);
    wr_rec(1'b0, 2, 32'h0, 32'h0, 16'h2000);
    lookup({3'd5, 29'h0});
    expect_res("R6 neutral", 1'b1, 13, 16'h3002);
    wr_rec(1'b0, 2, 32'h0, 32'h0, 16'h1000);
    lookup({3'd5, 29'h0});
    expect_res("R4 lowest", 1'b1, 2, 16'h1000);
    wr_sec(1'b0, 16'hFFFE);
    lookup({3'd5, 29'h0});
    expect_res("R5 sec0 off", 1'b1, 13, 16'h3002);
    wr_sec(1'b0, 16'hFFF2);
    lookup({3'd5, 29'h0});
    expect_res("R5 sec2-3 off", 1'b1, 20, 16'h1000);
    wr_sec(1'b0, 16'hFFFF);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1'b1; wr_id = 1'b0; wr_addr = IW'(1);
    wr_tag = 32'hCAFE_0001; wr_mask = 32'hFFFF_FFFF; wr_act = 16'h4009;
    lk_valid = 1'b1; lk_tag = 32'hCAFE_0001;
    @(negedge clk); wr_en = 1'b0; lk_valid = 1'b0;
    expect_res("R11 old contents", 1'b1, 2, 16'h1000);
    lookup(32'hCAFE_0001);
    expect_res("R11 new contents", 1'b1, 1, 16'h4009);
  endtask

  task automatic t_release;
    sem(2'b00, 2'b01);
    check("R9 owner release", 32'(gnt), 32'd0);
    sem(2'b10, 2'b00);
    check("R8 second master", 32'(gnt), 32'd2);
    wr_rec(1'b0, 0, 32'h0, 32'h0, 16'h4003);
    lookup(32'hCAFE_0001);
    expect_res("R10 old owner", 1'b1, 1, 16'h4009);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sem_acquire();
    t_exact();
    t_foreign_write();
    t_pcp();
    t_same_cycle();
    t_release();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule